// File: doc/BRIEF.md
# Fowler Multi-Sample Noise Reducer

This block takes the digitized samples of one pixel read non-destructively at regular intervals during one long integration, and reduces them to one value with less noise. A start marker, raised when the pixel is reset, opens a ramp of M samples. From then on every accepted sample belongs to that ramp, with indices counted from 0.

In Fowler mode the block sums the first N samples and the last N samples of the ramp. N is a power of two, so each mean is formed by a right shift. The result is the later mean minus the earlier mean, kept as a signed value. In fit mode the block gathers the two sums that a least-squares slope needs: the sum of the samples and the sum of index times sample. The sums of the index terms depend only on M, and the division happens outside the block.

Mode, N and M are captured at each start marker. A configuration with 2N larger than M is refused. A start marker that arrives before a ramp is complete abandons that ramp and reports it.

Top module: `fowler_ramp_reducer`

## Requirements
- R1: After reset, res_vld, cfg_err and ramp_abort are 0 and no result is produced until a ramp completes.
- R2: A start pulse clears all accumulators and captures cfg_fit, cfg_log2n and cfg_len. The next accepted sample has index 0.
- R3: In Fowler mode (cfg_fit=0), with N = 2**cfg_log2n and M = cfg_len, res_diff = floor(sum of samples M-N..M-1 / N) - floor(sum of samples 0..N-1 / N), as a 17-bit two's-complement value. A negative result is passed through unchanged. In this mode res_sum and res_isum are 0.
- R4: In fit mode (cfg_fit=1), res_sum is the sum of all M samples and res_isum is the sum of k*x[k] for k = 0..M-1. In this mode res_diff is 0.
- R5: res_vld is a one-cycle pulse on the clock edge after the edge that takes the M-th sample of the ramp.
- R6: If 2N > M at a start pulse (this includes M=0), cfg_err is 1 from the next cycle until the next start pulse, and that ramp produces no result.
- R7: A start pulse that arrives while a ramp is still collecting raises ramp_abort for exactly one cycle, on the next cycle. The new ramp then begins from cleared accumulators.
- R8: A sample is ignored if it is offered while no ramp is collecting, or in the same cycle as a start pulse.
- R9: With M=1024, N=512 and every sample equal to 65535, both modes return exact results with no overflow.
- R10: A cycle with smp_vld=0 inside a ramp does not advance the sample index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fit | input | 1 | 0 selects Fowler mode, 1 selects fit mode; captured at start |
| cfg_log2n | input | 4 | log2 of the group size N; captured at start |
| cfg_len | input | 11 | Ramp length M; captured at start |
| start | input | 1 | Pixel reset marker; opens a new ramp |
| smp_vld | input | 1 | smp_data carries a sample this cycle |
| smp_data | input | 16 | Unsigned sample value |
| res_vld | output | 1 | Result strobe |
| res_diff | output | 17 | Signed Fowler difference |
| res_sum | output | 27 | Sum of samples (fit mode) |
| res_isum | output | 38 | Sum of index times sample (fit mode) |
| cfg_err | output | 1 | The current configuration was refused |
| ramp_abort | output | 1 | The previous ramp was abandoned before it completed |

## Verification
A result is due one cycle after the last sample is taken, and cfg_err and ramp_abort are due one cycle after the start pulse. The bench changes inputs on falling edges, so the next falling edge after a sample or a start shows the registered response. At that edge the monitor compares the oldest queued expectation with any res_vld it sees, and the driver checks the two flags. A strobe with nothing queued is a miscompare, and so is an expectation still queued at the end. Together these catch results that are early, late, repeated or missing.

// File: rtl/fowler_ramp_reducer.sv
module fowler_ramp_reducer #(
  parameter int SW   = 16,
  parameter int MAXM = 1024,
  localparam int CW  = $clog2(MAXM + 1),
  localparam int NW  = $clog2(CW),
  localparam int AW  = SW + CW,
  localparam int IW  = SW + 2 * CW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_fit,
  input  logic [NW-1:0]        cfg_log2n,
  input  logic [CW-1:0]        cfg_len,
  input  logic                 start,
  input  logic                 smp_vld,
  input  logic [SW-1:0]        smp_data,
  output logic                 res_vld,
  output logic signed [SW:0]   res_diff,
  output logic [AW-1:0]        res_sum,
  output logic [IW-1:0]        res_isum,
  output logic                 cfg_err,
  output logic                 ramp_abort
);

  logic          active, fit_q;
  logic [NW-1:0] lg_q;
  logic [CW-1:0] len_q, cnt;
  logic [AW-1:0] sum, fsum, lsum;
  logic [IW-1:0] isum;

  logic [31:0] nval;
  logic        take, last, in_first, in_last, bad_cfg;
  logic [AW-1:0] sum_n, fsum_n, lsum_n;
  logic [IW-1:0] isum_n;
  logic signed [SW:0] diff_n;

  assign nval     = 32'd1 << lg_q;
  assign take     = smp_vld && active && !start;
  assign last     = cnt == len_q - 1'b1;
  assign in_first = 32'(cnt) < nval;
  assign in_last  = 32'(cnt) + nval >= 32'(len_q);
  assign bad_cfg  = (32'd2 << cfg_log2n) > 32'(cfg_len);

  assign sum_n  = sum + AW'(smp_data);
  assign isum_n = isum + IW'(cnt) * IW'(smp_data);
  assign fsum_n = in_first ? fsum + AW'(smp_data) : fsum;
  assign lsum_n = in_last  ? lsum + AW'(smp_data) : lsum;
  assign diff_n = $signed({1'b0, SW'(lsum_n >> lg_q)}) - $signed({1'b0, SW'(fsum_n >> lg_q)});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      fit_q      <= 1'b0;
      lg_q       <= '0;
      len_q      <= '0;
      cnt        <= '0;
      sum        <= '0;
      isum       <= '0;
      fsum       <= '0;
      lsum       <= '0;
      res_vld    <= 1'b0;
      res_diff   <= '0;
      res_sum    <= '0;
      res_isum   <= '0;
      cfg_err    <= 1'b0;
      ramp_abort <= 1'b0;
    end else begin
      res_vld    <= 1'b0;
      ramp_abort <= 1'b0;
      if (start) begin
        ramp_abort <= active;
        cfg_err    <= bad_cfg;
        active     <= !bad_cfg;
        fit_q      <= cfg_fit;
        lg_q       <= cfg_log2n;
        len_q      <= cfg_len;
        cnt        <= '0;
        sum        <= '0;
        isum       <= '0;
        fsum       <= '0;
        lsum       <= '0;
      end else if (take) begin
        cnt  <= cnt + 1'b1;
        sum  <= sum_n;
        isum <= isum_n;
        fsum <= fsum_n;
        lsum <= lsum_n;
        if (last) begin
          active   <= 1'b0;
          res_vld  <= 1'b1;
          res_diff <= fit_q ? '0 : diff_n;
          res_sum  <= fit_q ? sum_n : '0;
          res_isum <= fit_q ? isum_n : '0;
        end
      end
    end
  end

endmodule

// File: rtl/fowler_ramp_reducer_chk.sv
module fowler_ramp_reducer_chk #(
  parameter int SW = 16,
  parameter int AW = 27
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                smp_vld,
  input logic                fit_q,
  input logic                res_vld,
  input logic signed [SW:0]  res_diff,
  input logic [AW-1:0]       res_sum,
  input logic                cfg_err,
  input logic                ramp_abort
);

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n) res_vld |=> !res_vld); // R5
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n) cfg_err |-> !res_vld); // R6
  AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) ramp_abort |-> $past(start)); // R7
  AST_RES_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n) res_vld |-> ($past(smp_vld) && !$past(start))); // R8
  AST_FIT_DIFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (res_vld && fit_q) |-> res_diff == '0); // R4
  AST_FOWLER_SUM_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (res_vld && !fit_q) |-> res_sum == '0); // R3

endmodule

bind fowler_ramp_reducer fowler_ramp_reducer_chk #(.SW(SW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .smp_vld(smp_vld), .fit_q(fit_q),
  .res_vld(res_vld), .res_diff(res_diff), .res_sum(res_sum),
  .cfg_err(cfg_err), .ramp_abort(ramp_abort)
);

// File: tb/tb_fowler_ramp_reducer.sv
module tb_fowler_ramp_reducer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_fit = 1'b0;
  logic [3:0] cfg_log2n = '0;
  logic [10:0] cfg_len = '0;
  logic start = 1'b0;
  logic smp_vld = 1'b0;
  logic [15:0] smp_data = '0;
  logic res_vld;
  logic signed [16:0] res_diff;
  logic [26:0] res_sum;
  logic [37:0] res_isum;
  logic cfg_err, ramp_abort;

  int checks = 0;
  int fails = 0;
  bit open = 1'b0;
  longint q_diff[$];
  longint q_sum[$];
  longint q_isum[$];

  always #5 clk = ~clk;

  fowler_ramp_reducer dut (
    .clk(clk), .rst_n(rst_n), .cfg_fit(cfg_fit), .cfg_log2n(cfg_log2n), .cfg_len(cfg_len),
    .start(start), .smp_vld(smp_vld), .smp_data(smp_data), .res_vld(res_vld),
    .res_diff(res_diff), .res_sum(res_sum), .res_isum(res_isum),
    .cfg_err(cfg_err), .ramp_abort(ramp_abort)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint dat(input int pat, input int k);
    case (pat)
      0: return 1000 + 5 * k;
      1: return 60000 - 7 * k;
      2: return (k * 40503 + 12345) & 16'hffff;
      default: return 65535;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && res_vld) begin
      if (q_diff.size() == 0) begin
        check("R5 unexpected res_vld", 1, 0);
      end else begin
        check("R3 res_diff", longint'(res_diff), q_diff.pop_front());
        check("R4 res_sum", longint'(res_sum), q_sum.pop_front());
        check("R4 res_isum", longint'(res_isum), q_isum.pop_front());
      end
    end
  end

  task automatic ramp(input bit fit, input int lg, input int len, input int pat,
                      input bit gap, input int cnt);
    longint f = 0, l = 0, s = 0, i = 0, x;
    longint n = longint'(1) << lg;
    bit err = (2 * n) > len;
    for (int k = 0; k < len; k++) begin
      x = dat(pat, k);
      s += x;
      i += k * x;
      if (k < n) f += x;
      if (k >= len - n) l += x;
    end
    if (!err && cnt == len) begin
      q_diff.push_back(fit ? 0 : (l >>> lg) - (f >>> lg));
      q_sum.push_back(fit ? s : 0);
      q_isum.push_back(fit ? i : 0);
    end
    @(negedge clk);
    cfg_fit = fit; cfg_log2n = 4'(lg); cfg_len = 11'(len);
    start = 1'b1; smp_vld = 1'b1; smp_data = 16'd999;
    @(negedge clk);
    start = 1'b0; smp_vld = 1'b0;
    check("R6 cfg_err", longint'(cfg_err), longint'(err));
    check("R7 ramp_abort", longint'(ramp_abort), longint'(open));
    for (int k = 0; k < cnt; k++) begin
      if (gap && (k % 3 == 1)) @(negedge clk);
      smp_vld = 1'b1; smp_data = 16'(dat(pat, k));
      @(negedge clk);
      smp_vld = 1'b0;
    end
    open = !err && (cnt < len);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 res_vld", longint'(res_vld), 0);
    check("R1 cfg_err", longint'(cfg_err), 0);
    check("R1 ramp_abort", longint'(ramp_abort), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 res_vld after release", longint'(res_vld), 0);

    ramp(0, 1, 8, 0, 0, 8);      // R3 R2 rising ramp, N=2
    ramp(0, 2, 8, 1, 0, 8);      // R3 2N==M, negative difference
    ramp(1, 0, 10, 2, 1, 10);    // R4 R10 fit with gaps
    ramp(0, 0, 2, 2, 0, 2);      // R3 N=1 M=2
    ramp(0, 2, 6, 0, 0, 6);      // R6 2N>M refused, no result
    ramp(0, 1, 8, 0, 0, 3);      // R7 partial ramp
    ramp(0, 1, 8, 2, 1, 8);      // R7 abort then clean ramp
    for (int k = 0; k < 5; k++) begin // R8 idle samples
      smp_vld = 1'b1; smp_data = 16'(k * 777);
      @(negedge clk);
    end
    smp_vld = 1'b0;
    @(negedge clk);
    check("R8 idle no result", longint'(res_vld), 0);
    ramp(0, 9, 1024, 3, 0, 1024); // R9 Fowler full scale
    ramp(1, 9, 1024, 3, 0, 1024); // R9 fit full scale
    ramp(0, 3, 40, 2, 0, 40);     // R3 N=8 pseudo-random
    ramp(1, 0, 0, 0, 0, 0);       // R6 M=0 refused
    repeat (5) @(negedge clk);
    check("R5 missing results", longint'(q_diff.size()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule